// File: doc/BRIEF.md
# Programmable AND-OR Term Plane

This block is the logic core of a small programmable logic cell group. Ten dedicated inputs and eight feedback lines from the output cells give eighteen signals. Each signal drives two array columns, one true and one inverted. Every row of the array is a product term. It is the AND of the columns whose cell is connected in that row. The rows are split into one group per output cell. Within each group, most rows are ORed into a sum-of-products result. The last row of the group becomes that output's driver-enable (direction) term. Two more rows are shared by all outputs: one drives the register preset and the other drives the register reset.

The cell pattern (the fuse map) is shifted in serially while a load strobe is high. The map is adopted when the strobe falls, but only if both shared control rows have at least one connected cell. A shared row with no connected cell would be constantly true, so such a map is rejected and the previous map stays in use. After reset every cell is connected. This is the unprogrammed state, and in it every term is 0. All results leave the block through registers.

Top module: `pla_array`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 after that edge, and the map returns to the unprogrammed state in which every cell is connected.
- R2: Signal s (s = 0..9 is `in_sig[s]`, s = 10..17 is `fb_sig[s-10]`) drives column 2s with its true value and column 2s+1 with its inverse.
- R3: Fuse bit `row*36 + col` set to 1 connects that column to that row; a row's term is the AND of all its connected columns.
- R4: A row with no connected cell gives a term of 1.
- R5: A row in which both columns of any signal are connected gives a term of 0; the unprogrammed map therefore drives every output to 0.
- R6: For output o, rows 9o..9o+7 are ORed into `sop_out[o]` and row 9o+8 drives `dir_out[o]`.
- R7: Row 72 drives `preset_term` and row 73 drives `reset_term`.
- R8: Every output shows the terms computed from the inputs and map present at the previous clock edge (one register stage).
- R9: At each edge where `ld_en` is high, `ld_bit` is shifted into a staging register. After 2664 such shifts, the first bit shifted is fuse bit 0 and the last is fuse bit 2663.
- R10: The staged map becomes the active map at the first edge where `ld_en` is low after having been high. Before then, outputs keep using the previous map, including while shifting is in progress.
- R11: A staged map in which row 72 or row 73 has no connected cell is rejected at that edge, and the previous active map stays in force.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Serial map load strobe; its falling edge commits |
| ld_bit | input | 1 | Serial map data, fuse bit 0 first |
| in_sig | input | 10 | Dedicated inputs |
| fb_sig | input | 8 | Feedback from the output cells |
| sop_out | output | 8 | Registered sum-of-products, one per output |
| dir_out | output | 8 | Registered direction term, one per output |
| preset_term | output | 1 | Registered shared preset term |
| reset_term | output | 1 | Registered shared reset term |

## Verification
The assertions assume that a load shifts a whole map before `ld_en` drops. They also assume that `ld_en` is steady between edges. With both held, the staging register holds exactly the bits sent. The stimulus keeps to this: every load sends all 2664 bits in index order and then lowers the strobe for several cycles. The data and feedback inputs are random 18-bit patterns and may change freely. The maps are random and sparse so that terms are true often enough to matter. They also include directed rows with a single literal, with no cells at all, and a map with an empty preset row that must be rejected.

// File: rtl/pla_pkg.sv
package pla_pkg;
  // default geometry of the term plane
  localparam int DEF_N_IN  = 10;
  localparam int DEF_N_FB  = 8;
  localparam int DEF_N_OUT = 8;
  localparam int DEF_N_SUM = 8;

  // row index of sum term k of output o
  function automatic int sum_row(input int o, input int k, input int per);
    return o * per + k;
  endfunction

  // row index of the direction term of output o
  function automatic int dir_row(input int o, input int per, input int nsum);
    return o * per + nsum;
  endfunction
endpackage

// File: rtl/pla_fuse_loader.sv
module pla_fuse_loader #(
  parameter int ROWS       = 74,
  parameter int COLS       = 36,
  parameter int PRESET_ROW = 72,
  parameter int RESET_ROW  = 73
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_en,
  input  logic                 ld_bit,
  output logic [ROWS*COLS-1:0] fuse_map
);
  localparam int TOT = ROWS * COLS;

  logic [TOT-1:0] stage;
  logic           ld_en_q;
  logic           commit;
  logic           staged_ok;

  assign commit    = ld_en_q & ~ld_en;
  assign staged_ok = (|stage[PRESET_ROW*COLS +: COLS]) & (|stage[RESET_ROW*COLS +: COLS]);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage    <= '1;
      fuse_map <= '1;
      ld_en_q  <= 1'b0;
    end else begin
      ld_en_q <= ld_en;
      if (ld_en)
        stage <= {ld_bit, stage[TOT-1:1]};
      if (commit && staged_ok)
        fuse_map <= stage;
    end
  end

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (stage[TOT-1] == $past(ld_bit))); // R9

  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(ld_en_q && !ld_en) |=> $stable(fuse_map)); // R10

  AST_REJECT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (ld_en_q && !ld_en && !staged_ok) |=> $stable(fuse_map)); // R11

  AST_GLOBALS_LIVE: assert property (@(posedge clk) disable iff (rst)
    (|fuse_map[PRESET_ROW*COLS +: COLS]) && (|fuse_map[RESET_ROW*COLS +: COLS])); // R11
endmodule

// File: rtl/pla_term.sv
module pla_term #(
  parameter int COLS = 36
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [COLS-1:0] fuse_row,
  input  logic [COLS-1:0] col_vec,
  output logic            term
);
  localparam int NSIG = COLS / 2;

  logic contradict;

  // unconnected columns read as 1 so they drop out of the AND
  assign term = &(~fuse_row | col_vec);

  always_comb begin
    contradict = 1'b0;
    for (int s = 0; s < NSIG; s++)
      contradict = contradict | (fuse_row[2*s] & fuse_row[2*s+1]);
  end

  AST_CONTRADICT_LOW: assert property (@(posedge clk) disable iff (rst)
    contradict |-> !term); // R5
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_OUT = 8,
  parameter int N_SUM = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_OUT*(N_SUM+1)-1:0]   grp_terms,
  input  logic [1:0]                   glob_terms,
  output logic [N_OUT-1:0]             sop_q,
  output logic [N_OUT-1:0]             dir_q,
  output logic                         preset_q,
  output logic                         reset_q
);
  import pla_pkg::*;
  localparam int PER = N_SUM + 1;

  logic [N_OUT-1:0] sop_d;
  logic [N_OUT-1:0] dir_d;

  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      sop_d[o] = |grp_terms[sum_row(o, 0, PER) +: N_SUM];
      dir_d[o] = grp_terms[dir_row(o, PER, N_SUM)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sop_q    <= '0;
      dir_q    <= '0;
      preset_q <= 1'b0;
      reset_q  <= 1'b0;
    end else begin
      sop_q    <= sop_d;
      dir_q    <= dir_d;
      preset_q <= glob_terms[0];
      reset_q  <= glob_terms[1];
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_chk
    AST_OR_NONE: assert property (@(posedge clk) disable iff (rst)
      (grp_terms[o*PER +: N_SUM] == '0) |=> !sop_q[o]); // R6
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (sop_q == '0 && dir_q == '0 && !preset_q && !reset_q)); // R1
endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN  = pla_pkg::DEF_N_IN,
  parameter int N_FB  = pla_pkg::DEF_N_FB,
  parameter int N_OUT = pla_pkg::DEF_N_OUT,
  parameter int N_SUM = pla_pkg::DEF_N_SUM
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic             ld_bit,
  input  logic [N_IN-1:0]  in_sig,
  input  logic [N_FB-1:0]  fb_sig,
  output logic [N_OUT-1:0] sop_out,
  output logic [N_OUT-1:0] dir_out,
  output logic             preset_term,
  output logic             reset_term
);
  localparam int NSIG       = N_IN + N_FB;
  localparam int COLS       = 2 * NSIG;
  localparam int PER        = N_SUM + 1;
  localparam int GRP_ROWS   = N_OUT * PER;
  localparam int PRESET_ROW = GRP_ROWS;
  localparam int RESET_ROW  = GRP_ROWS + 1;
  localparam int ROWS       = GRP_ROWS + 2;

  logic [NSIG-1:0]      sig;
  logic [COLS-1:0]      col_vec;
  logic [ROWS*COLS-1:0] fuse_map;
  logic [ROWS-1:0]      terms;

  assign sig = {fb_sig, in_sig};

  for (genvar s = 0; s < NSIG; s++) begin : g_col
    assign col_vec[2*s]   = sig[s];
    assign col_vec[2*s+1] = ~sig[s];
  end

  pla_fuse_loader #(
    .ROWS(ROWS), .COLS(COLS), .PRESET_ROW(PRESET_ROW), .RESET_ROW(RESET_ROW)
  ) u_loader (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_bit(ld_bit), .fuse_map(fuse_map)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    pla_term #(.COLS(COLS)) u_term (
      .clk(clk), .rst(rst),
      .fuse_row(fuse_map[r*COLS +: COLS]),
      .col_vec(col_vec),
      .term(terms[r])
    );
  end

  pla_or_plane #(.N_OUT(N_OUT), .N_SUM(N_SUM)) u_or (
    .clk(clk), .rst(rst),
    .grp_terms(terms[GRP_ROWS-1:0]),
    .glob_terms(terms[RESET_ROW:PRESET_ROW]),
    .sop_q(sop_out), .dir_q(dir_out),
    .preset_q(preset_term), .reset_q(reset_term)
  );
endmodule

// File: tb/pla_array_test.sv
module pla_array_test;
  localparam int COLS = 36;
  localparam int ROWS = 74;
  localparam int TOT  = ROWS * COLS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0, ld_bit = 1'b0;
  logic [9:0] in_sig = '0;
  logic [7:0] fb_sig = '0;
  logic [7:0] sop_out, dir_out;
  logic preset_term, reset_term;

  int total = 0, bad = 0;
  bit done = 0;
  bit [TOT-1:0] bmap, nmap;

  pla_array uut (.clk(clk), .rst(rst), .ld_en(ld_en), .ld_bit(ld_bit),
    .in_sig(in_sig), .fb_sig(fb_sig), .sop_out(sop_out), .dir_out(dir_out),
    .preset_term(preset_term), .reset_term(reset_term));

  always #5 clk = ~clk;

  function automatic bit term_of(bit [TOT-1:0] m, int row, bit [17:0] s);
    bit r = 1'b1;
    for (int c = 0; c < COLS; c++)
      if (m[row*COLS + c]) r &= (c % 2 == 0) ? s[c/2] : ~s[c/2];
    return r;
  endfunction

  function automatic bit [17:0] exp_vec(bit [TOT-1:0] m, bit [17:0] s);
    bit [17:0] v = '0;
    for (int o = 0; o < 8; o++) begin
      for (int k = 0; k < 8; k++) v[o] |= term_of(m, o*9 + k, s);
      v[8+o] = term_of(m, o*9 + 8, s);
    end
    v[16] = term_of(m, 72, s);
    v[17] = term_of(m, 73, s);
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req, bit [17:0] e);
    chk({req, " R6 sop"}, 32'(sop_out), 32'(e[7:0]));
    chk({req, " R6 dir"}, 32'(dir_out), 32'(e[15:8]));
    chk({req, " R7 preset"}, 32'(preset_term), 32'(e[16]));
    chk({req, " R7 reset"}, 32'(reset_term), 32'(e[17]));
  endtask

  // drive at a negedge, result visible one posedge later (R8)
  task automatic apply(bit [9:0] i, bit [7:0] f);
    in_sig = i; fb_sig = f;
    @(negedge clk);
  endtask

  task automatic load(bit [TOT-1:0] m);
    for (int k = 0; k < TOT; k++) begin
      @(negedge clk);
      if (k == TOT/2) chk_all("R10 mid-load", exp_vec(bmap, {fb_sig, in_sig}));
      ld_en = 1'b1; ld_bit = m[k];
    end
    @(negedge clk);
    ld_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic bit globals_ok(bit [TOT-1:0] m);
    return (|m[72*COLS +: COLS]) && (|m[73*COLS +: COLS]);
  endfunction

  function automatic bit [TOT-1:0] rand_map();
    bit [TOT-1:0] m;
    for (int k = 0; k < TOT; k++) m[k] = ($urandom % 10 == 0);
    for (int c = 0; c < COLS; c++) m[3*COLS + c] = 1'b0;   // empty row
    m[72*COLS + 4] = 1'b1;
    m[73*COLS + 7] = 1'b1;
    return m;
  endfunction

  task automatic random_run(string req, int n);
    for (int t = 0; t < n; t++) begin
      bit [9:0] i = 10'($urandom);
      bit [7:0] f = 8'($urandom);
      apply(i, f);
      chk_all(req, exp_vec(bmap, {f, i}));
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    bmap = '1;
    repeat (3) @(negedge clk);
    chk("R1 sop after reset", 32'(sop_out), 0);
    chk("R1 dir after reset", 32'(dir_out), 0);
    chk("R1 globals after reset", 32'({preset_term, reset_term}), 0);
    rst = 1'b0;
    @(negedge clk);

    random_run("R5 virgin", 20);

    // random map with an empty row 3 (R3 R4 R9)
    nmap = rand_map();
    load(nmap);
    bmap = nmap;
    random_run("R3 R9 map A", 300);
    apply(10'h000, 8'h00);
    chk("R4 empty row 3 forces sop0", 32'(sop_out[0]), 1);

    // latency: output changes only after the edge (R8)
    begin
      bit [17:0] e_old = exp_vec(bmap, {fb_sig, in_sig});
      bit [9:0] i = 10'h3a5;
      bit [7:0] f = 8'h5c;
      in_sig = i; fb_sig = f;
      #1 chk("R8 before edge", 32'(sop_out), 32'(e_old[7:0]));
      @(negedge clk);
      chk("R8 after edge", 32'(sop_out), 32'(exp_vec(bmap, {f, i}) & 18'hff));
    end

    // rejected map: empty preset row (R11)
    nmap = rand_map();
    for (int c = 0; c < COLS; c++) nmap[72*COLS + c] = 1'b0;
    if (globals_ok(nmap)) bmap = nmap;
    load(nmap);
    random_run("R11 rejected keeps map A", 100);

    // directed single-literal map (R2 R4 R7)
    nmap = '1;
    for (int c = 0; c < COLS; c++) begin
      nmap[0*COLS + c]  = (c == 0);
      nmap[1*COLS + c]  = (c == 21);
      nmap[8*COLS + c]  = 1'b0;
      nmap[72*COLS + c] = (c == 2);
      nmap[73*COLS + c] = (c == 3);
    end
    load(nmap);
    bmap = nmap;
    apply(10'h001, 8'h01);
    chk("R2 in0 true column", 32'(sop_out[0]), 1);
    apply(10'h000, 8'h01);
    chk("R2 fb0 complement column off", 32'(sop_out[0]), 0);
    apply(10'h000, 8'h00);
    chk("R2 fb0 complement column on", 32'(sop_out[0]), 1);
    chk("R4 empty direction row", 32'(dir_out[0]), 1);
    apply(10'h002, 8'h00);
    chk("R7 preset on in1", 32'({preset_term, reset_term}), 32'h2);
    apply(10'h000, 8'h00);
    chk("R7 reset on not in1", 32'({preset_term, reset_term}), 32'h1);
    random_run("R5 R6 map B", 200);

    // reset returns to virgin map (R1)
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    bmap = '1;
    chk("R1 sop cleared", 32'(sop_out), 0);
    random_run("R1 R5 virgin after reset", 20);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule